// File: doc/BRIEF.md
# Input Period Timeout Detector

The block watches one asynchronous digital input and reports when that input has gone too long without a rising edge. Each detected rising edge starts a count of system clock cycles. If the count passes a programmable limit before the next rising edge arrives, the `overdue` flag goes high at once, in the middle of the period, rather than at the end of it. The flag stays high until a rising edge is seen again, and the measurement then starts over.

The input first passes through a two-flop synchronizer. A rising edge is taken as a synchronized high that follows a synchronized low. A small state machine has three states:
- `PW_IDLE`: reset, no edge seen yet.
- `PW_TIMING`: counting since the last edge.
- `PW_OVERDUE`: the limit has been passed.

It has these transitions:
- IDLE→TIMING on the first edge.
- TIMING→TIMING on an edge, which restarts the count.
- TIMING→OVERDUE when the count has reached the limit and no edge is present in that cycle.
- OVERDUE→TIMING on an edge.

The flag is high exactly in `PW_OVERDUE`. The limit port is read live on every cycle.

Top module: `period_watchdog`

## Requirements
- R1: After reset `overdue` is 0. It stays 0 for any length of time until the first rising edge of `sig_in` has been detected.
- R2: If consecutive rising edges of `sig_in` are sampled at most `limit_cycles`+1 clock cycles apart, `overdue` stays 0.
- R3: Let the first clock edge that samples `sig_in` high after a low be edge k. If no further rise follows, `overdue` is 0 after clock edge k+`limit_cycles`+2 and is 1 after clock edge k+`limit_cycles`+3.
- R4: Once high, `overdue` stays 1 for as long as no new rising edge of `sig_in` arrives.
- R5: A new rise of `sig_in` first sampled at clock edge k clears `overdue`. It is still 1 after edge k+1, it is 0 after edge k+2, and a new timing period starts from that rise.
- R6: If consecutive rises are sampled exactly `limit_cycles`+2 cycles apart, `overdue` is high for exactly one clock cycle in that period. When the limit is reached in the same cycle as an edge, the edge wins and no flag is raised.
- R7: With `limit_cycles` = 0, `overdue` rises after clock edge k+3 for a rise sampled at edge k.
- R8: A change of `limit_cycles` takes effect during the running period. If the elapsed count already meets the new limit, `overdue` rises at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Watched input, asynchronous to `clk` |
| limit_cycles | input | CW (16) | Maximum allowed cycles after an edge, unsigned |
| overdue | output | 1 | High while the time since the last rising edge exceeds the limit |

## Verification
Two of the block's functions can land in the same cycle: detection of a new input edge, and expiry of the limit. This happens when two rises are sampled exactly `limit_cycles`+1 cycles apart. The bench provokes it by running a train of such periods and requiring the flag to stay low on every cycle, so the restart must take priority over expiry. It then stretches one period by a single cycle and requires exactly one cycle of `overdue`, which pins the boundary from both sides.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        PW_IDLE    = 2'd0,
        PW_TIMING  = 2'd1,
        PW_OVERDUE = 2'd2
    } pw_state_e;

endpackage

// File: rtl/pw_sync.sv
// Synchronizer chain for one asynchronous bit followed by a rising-edge detector.
module pw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pw_elapsed.sv
// Elapsed-cycle counter: cleared by a restart, advanced only while enabled.
module pw_elapsed #(
    parameter int CW = 16,
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    input  logic [CW-1:0] limit,
    output logic [NW-1:0] count,
    output logic          at_limit
);

    logic [NW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + NW'(1);
        end
    end

    assign count    = count_q;
    assign at_limit = (count_q >= {1'b0, limit});

endmodule

// File: rtl/pw_fsm.sv
// Three-state controller; the flag is decoded from the state register alone.
module pw_fsm
    import pw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_seen,
    input  logic      at_limit,
    output pw_state_e state,
    output logic      count_en,
    output logic      flag
);

    pw_state_e state_q;
    pw_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                if (edge_seen) state_d = PW_TIMING;
            end
            PW_TIMING: begin
                if (edge_seen)     state_d = PW_TIMING;
                else if (at_limit) state_d = PW_OVERDUE;
            end
            PW_OVERDUE: begin
                if (edge_seen) state_d = PW_TIMING;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PW_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        count_en = 1'b0;
        flag     = 1'b0;
        unique case (state_q)
            PW_IDLE:    begin count_en = 1'b0; flag = 1'b0; end
            PW_TIMING:  begin count_en = 1'b1; flag = 1'b0; end
            PW_OVERDUE: begin count_en = 1'b0; flag = 1'b1; end
            default:    begin count_en = 1'b0; flag = 1'b0; end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/period_watchdog.sv
module period_watchdog
    import pw_pkg::*;
#(
    parameter int CW      = 16,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sig_in,
    input  logic [CW-1:0] limit_cycles,
    output logic          overdue
);

    localparam int NW = CW + 1;

    logic          sig_level;
    logic          edge_pulse;
    logic          count_en;
    logic          at_limit;
    logic [NW-1:0] elapsed;
    pw_state_e     state_q;

    pw_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sig_in),
        .level    (sig_level),
        .rise     (edge_pulse)
    );

    pw_elapsed #(.CW(CW)) u_elapsed (
        .clk      (clk),
        .rst      (rst),
        .restart  (edge_pulse),
        .advance  (count_en),
        .limit    (limit_cycles),
        .count    (elapsed),
        .at_limit (at_limit)
    );

    pw_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .edge_seen (edge_pulse),
        .at_limit  (at_limit),
        .state     (state_q),
        .count_en  (count_en),
        .flag      (overdue)
    );

endmodule

// File: rtl/pw_checker.sv
module pw_checker
    import pw_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          edge_pulse,
    input pw_state_e     state_q,
    input logic [CW:0]   elapsed,
    input logic [CW-1:0] limit_cycles,
    input logic          overdue
);

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_IDLE) |-> !overdue);                                  // R1

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_TIMING && $stable(limit_cycles)) |-> (elapsed <= {1'b0, limit_cycles})); // R2

    AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(overdue) |-> ($past(elapsed) >= {1'b0, $past(limit_cycles)})); // R3

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (overdue && !edge_pulse) |=> overdue);                               // R4

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !overdue);                                            // R5

    AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> (elapsed == '0));                                     // R5

endmodule

bind period_watchdog pw_checker #(.CW(CW)) u_pw_checker (
    .clk          (clk),
    .rst          (rst),
    .edge_pulse   (edge_pulse),
    .state_q      (state_q),
    .elapsed      (elapsed),
    .limit_cycles (limit_cycles),
    .overdue      (overdue)
);

// File: tb/tb_period_watchdog.sv
`timescale 1ns/1ps
module tb_period_watchdog;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sig_in = 1'b0;
    logic [CW-1:0] limit_cycles = '0;
    logic          overdue;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    period_watchdog #(.CW(CW)) dut (
        .clk          (clk),
        .rst          (rst),
        .sig_in       (sig_in),
        .limit_cycles (limit_cycles),
        .overdue      (overdue)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (overdue !== exp) begin
            fails++;
            $display("FAIL %s: overdue=%b expected=%b at %0t", tag, overdue, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sig_in = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    // One-cycle high pulse; on return one posedge has sampled it (relative r=1).
    task automatic launch_rise();
        sig_in = 1'b1;
        step(1);
        sig_in = 1'b0;
    endtask

    task automatic test_reset_quiet();
        do_reset();
        limit_cycles = 16'd4;
        check(1'b0, "R1 reset");
        for (int i = 0; i < 15; i++) begin
            step(10);
            check(1'b0, "R1 idle");
        end
    endtask

    // Rises every p cycles; flag must stay low on every cycle.
    task automatic run_periods(input int p, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            launch_rise();
            check(1'b0, tag);
            for (int r = 2; r <= p; r++) begin
                step(1);
                check(1'b0, tag);
            end
        end
    endtask

    task automatic test_short_periods();
        do_reset();
        limit_cycles = 16'd20;
        run_periods(10, 6, "R2 short");
        run_periods(7, 6, "R2 shorter");
    endtask

    task automatic test_timeout_and_clear(input int lim);
        do_reset();
        limit_cycles = CW'(lim);
        launch_rise();
        step(lim + 2);
        check(1'b0, "R3 before limit");
        step(1);
        check(1'b1, "R3 at limit");
        for (int i = 0; i < 40; i++) begin
            step(1);
            check(1'b1, "R4 hold");
        end
        launch_rise();
        check(1'b1, "R5 r=1");
        step(1);
        check(1'b1, "R5 r=2");
        step(1);
        check(1'b0, "R5 cleared");
        step(lim);
        check(1'b0, "R5 new period before limit");
        step(1);
        check(1'b1, "R5 new period at limit");
    endtask

    task automatic test_boundary();
        do_reset();
        limit_cycles = 16'd12;
        run_periods(13, 6, "R6 period limit+1");
        launch_rise();
        step(12);
        check(1'b0, "R6 r=limit+1");
        step(1);
        launch_rise();
        check(1'b0, "R6 r=limit+3");
        step(1);
        check(1'b1, "R6 single cycle high");
        step(1);
        check(1'b0, "R6 low again");
    endtask

    task automatic test_zero_limit();
        do_reset();
        limit_cycles = '0;
        launch_rise();
        step(1);
        check(1'b0, "R7 r=2");
        step(1);
        check(1'b0, "R7 r=3");
        step(1);
        check(1'b1, "R7 r=4");
    endtask

    task automatic test_live_limit();
        do_reset();
        limit_cycles = 16'd200;
        launch_rise();
        step(29);
        check(1'b0, "R8 before change");
        limit_cycles = 16'd5;
        step(1);
        check(1'b1, "R8 after lowering");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        test_reset_quiet();
        test_short_periods();
        test_timeout_and_clear(9);
        test_timeout_and_clear(1);
        test_boundary();
        test_zero_limit();
        test_live_limit();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
        finish_run();
    end

endmodule